// File: doc/BRIEF.md
# Display Cycle-Steal Arbiter

This block shares storage cycles between the processor and a display refresh engine. The display engine fetches characters by taking over single storage cycles. When the display raises a request, the arbiter hands it the current cycle, but only if steals are enabled and the cycle just before was not already taken. Every cycle the display does not receive belongs to the processor. Data read during a stolen cycle comes back on the shared read bus. Both the display and the processor can see it there, so the arbiter does not route any data.

The arbiter also generates the display fetch address. There are two fixed windows, selected by a mode input. Register view covers the low 512 locations. Normal view covers the 1024 locations that follow them. The address steps forward once after each grant and wraps at the end of its window. A change of mode sends it back to the start of the new window.

Microcode can set or clear a steal-enable flag. A process-check event forces the flag on. Three outputs show the disabled state: a display-off line, a blank-display line and an in-process indicator.

Top module: `disp_steal_ctrl`

## Requirements
- R1: After reset, steals are disabled. `steal_gnt` is 0, `blank`, `in_proc` and `disp_off` are 1, and `steal_addr` is the start of the selected window.
- R2: In a given cycle, `steal_gnt` is 1 exactly when three things hold: `disp_req` is 1, steals are enabled, and the previous cycle was not granted. Otherwise the processor owns the cycle.
- R3: `steal_gnt` is never 1 on two consecutive cycles.
- R4: With `reg_view`=1, `steal_addr` stays in 0x000..0x1FF. It rises by one in the cycle after each grant, and after a grant at 0x1FF it returns to 0x000.
- R5: With `reg_view`=0, `steal_addr` stays in 0x200..0x5FF. It rises by one in the cycle after each grant, and after a grant at 0x5FF it returns to 0x200.
- R6: In the first cycle in which `reg_view` differs from its value in the previous cycle, `steal_addr` equals the start of the new window (0x000 or 0x200).
- R7: A cycle with `en_set`=1 enables steals from the next cycle on. A cycle with `en_clr`=1 disables them from the next cycle on. When both are 1, the clear wins.
- R8: `blank`, `in_proc` and `disp_off` are all 1 while steals are disabled and all 0 while they are enabled.
- R9: A cycle with `proc_check`=1 enables steals from the next cycle on, whatever `en_clr` and `en_set` are doing.
- R10: If a cycle is not granted and `reg_view` does not change, `steal_addr` keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_req | input | 1 | Display engine asks for the current cycle |
| reg_view | input | 1 | 1 selects the register window, 0 selects the normal window |
| en_set | input | 1 | Microcode command that enables steals |
| en_clr | input | 1 | Microcode command that disables steals |
| proc_check | input | 1 | Process-check event; forces steals on |
| steal_gnt | output | 1 | The current cycle is given to the display |
| steal_addr | output | 11 | Display fetch address for the current cycle |
| disp_off | output | 1 | Steals are disabled |
| blank | output | 1 | Display is blanked |
| in_proc | output | 1 | In-process indicator |

## Verification
A wrong enable flag shows up in the first cycle after the offending command. `blank` and the indicator lines take the wrong value, and a pending request is granted or refused incorrectly. A lost or duplicated address step does not correct itself: every later fetch address is off by the same amount, and the error is visible at the next granted cycle. A wrong record of the previous cycle's owner appears as a double grant, or as a missing grant under a continuous request, within two cycles. Comparing every output against the model on every cycle catches each of these at the cycle where it first appears.

// File: rtl/disp_steal_ctrl.sv
module disp_steal_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int REG_BASE  = 'h000,
  parameter int REG_DEPTH = 512,
  parameter int NRM_BASE  = 'h200,
  parameter int NRM_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_req,
  input  logic              reg_view,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              proc_check,
  output logic              steal_gnt,
  output logic [ADDR_W-1:0] steal_addr,
  output logic              disp_off,
  output logic              blank,
  output logic              in_proc
);
  localparam int MAXD  = (REG_DEPTH > NRM_DEPTH) ? REG_DEPTH : NRM_DEPTH;
  localparam int OFF_W = $clog2(MAXD);

  logic             en_q, last_q, mode_q, mode_chg;
  logic [OFF_W-1:0] off_q, off_cur, off_last;

  assign mode_chg   = reg_view != mode_q;
  assign off_cur    = mode_chg ? '0 : off_q;
  assign off_last   = reg_view ? OFF_W'(REG_DEPTH - 1) : OFF_W'(NRM_DEPTH - 1);
  assign steal_gnt  = disp_req & en_q & ~last_q;
  assign steal_addr = (reg_view ? ADDR_W'(REG_BASE) : ADDR_W'(NRM_BASE)) + ADDR_W'(off_cur);
  assign disp_off   = ~en_q;
  assign blank      = ~en_q;
  assign in_proc    = ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      last_q <= 1'b0;
      mode_q <= 1'b1;
      off_q  <= '0;
    end else begin
      last_q <= steal_gnt;
      mode_q <= reg_view;
      if (steal_gnt) off_q <= (off_cur == off_last) ? '0 : off_cur + 1'b1;
      else           off_q <= off_cur;
      if (proc_check)  en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
    end
  end
endmodule

module disp_steal_chk #(
  parameter int ADDR_W    = 11,
  parameter int REG_BASE  = 'h000,
  parameter int REG_DEPTH = 512,
  parameter int NRM_BASE  = 'h200,
  parameter int NRM_DEPTH = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_req,
  input logic              reg_view,
  input logic              en_set,
  input logic              en_clr,
  input logic              proc_check,
  input logic              steal_gnt,
  input logic [ADDR_W-1:0] steal_addr,
  input logic              disp_off,
  input logic              blank,
  input logic              in_proc
);
  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    steal_gnt |-> (disp_req && !blank));
  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    steal_gnt |=> !steal_gnt);
  assert_reg_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_view |-> (int'(steal_addr) < REG_BASE + REG_DEPTH));
  assert_nrm_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_view |-> (int'(steal_addr) >= NRM_BASE && int'(steal_addr) < NRM_BASE + NRM_DEPTH));
  assert_mode_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_view != $past(reg_view)) |->
      (int'(steal_addr) == (reg_view ? REG_BASE : NRM_BASE)));
  assert_clear_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !proc_check) |=> blank);
  assert_status_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank == in_proc) && (blank == disp_off));
  assert_check_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_check |=> !blank);
  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !steal_gnt |=> ((reg_view != $past(reg_view)) || $stable(steal_addr)));
endmodule

bind disp_steal_ctrl disp_steal_chk #(
  .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .REG_DEPTH(REG_DEPTH),
  .NRM_BASE(NRM_BASE), .NRM_DEPTH(NRM_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .reg_view(reg_view),
  .en_set(en_set), .en_clr(en_clr), .proc_check(proc_check),
  .steal_gnt(steal_gnt), .steal_addr(steal_addr), .disp_off(disp_off),
  .blank(blank), .in_proc(in_proc)
);

// File: tb/sim_disp_steal_ctrl.sv
`timescale 1ns/1ps
module sim_disp_steal_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_req = 0, reg_view = 1, en_set = 0, en_clr = 0, proc_check = 0;
  logic steal_gnt, disp_off, blank, in_proc;
  logic [10:0] steal_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_en = 0, m_last = 0, m_mode = 1, m_off = 0;

  always #10 clk = ~clk;

  disp_steal_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .reg_view(reg_view),
    .en_set(en_set), .en_clr(en_clr), .proc_check(proc_check),
    .steal_gnt(steal_gnt), .steal_addr(steal_addr), .disp_off(disp_off),
    .blank(blank), .in_proc(in_proc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit req, input bit view, input bit set, input bit clr, input bit pc);
    int base, depth, offc, g;
    bit chg;
    @(negedge clk);
    disp_req = req; reg_view = view; en_set = set; en_clr = clr; proc_check = pc;
    #2;
    base  = view ? 'h000 : 'h200;
    depth = view ? 512 : 1024;
    chg   = (view != m_mode);
    offc  = chg ? 0 : m_off;
    g     = (req && m_en && !m_last) ? 1 : 0;
    chk("R2 steal_gnt", steal_gnt, g);
    if (m_last) chk("R3 no back-to-back grant", steal_gnt, 0);
    chk(chg ? "R6 steal_addr" : (view ? "R4 steal_addr" : "R5 steal_addr"),
        steal_addr, base + offc);
    chk("R8 blank", blank, !m_en);
    chk("R8 in_proc", in_proc, !m_en);
    chk("R8 disp_off", disp_off, !m_en);
    m_off  = g ? ((offc == depth - 1) ? 0 : offc + 1) : offc;  // R10 hold when no grant
    m_last = g;
    m_mode = view;
    if (pc) m_en = 1;         // R9
    else if (clr) m_en = 0;   // R7
    else if (set) m_en = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 steal_gnt", steal_gnt, 0);
    chk("R1 blank", blank, 1);
    chk("R1 in_proc", in_proc, 1);
    chk("R1 disp_off", disp_off, 1);
    chk("R1 steal_addr", steal_addr, 0);
    // R2 requests ignored while disabled
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0);
    // R7 enable, then register window wrap R4
    step(0, 1, 1, 0, 0);
    for (int i = 0; i < 1100; i++) step(1, 1, 0, 0, 0);
    // R7 clear beats set
    step(1, 1, 1, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
    // R9 process check beats clear
    step(1, 1, 0, 1, 1);
    // R5 normal window wrap, entered via mode change R6
    for (int i = 0; i < 2100; i++) step(1, 0, 0, 0, 0);
    // R6 mode toggles mid stream, R10 holds with idle gaps
    for (int i = 0; i < 40; i++) step(i % 3 != 0, (i / 7) % 2 == 1, 0, 0, 0);
    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      step(r[2:0] != 0, (r[15:8] == 0) ? !reg_view : reg_view,
           r[23:19] == 0, r[28:24] == 0, r[31:27] == 0 && r[3]);
    end
    finish_run();
  end
endmodule